// File: doc/BRIEF.md
# Power Monitor Command and Readback Serial Target

This block is the serial-bus target of a power-monitor device. It watches the two-wire bus (clock and open-drain data) by oversampling both lines on the system clock. It answers to one 7-bit address: a fixed five-bit prefix followed by two strap bits. The transactions it handles are:

- a presence probe, which is the address and a write bit followed by a stop;
- a one-byte command write, which loads the conversion command bits;
- a two-byte write to one of three alert-side registers;
- multi-byte reads of the latest conversion results.

The first byte written after the address is either a command or an indirect register select, and its top bit decides which. On a read, the block takes a snapshot of the voltage code, the current code and the status byte. It then sends two or three bytes packed according to the enabled channels, or one status byte when status readback is selected. When the conversion sequencer reports that no result is available, the block declines the read address. The command bits go straight to the sequencer. Register writes leave the block as a one-cycle strobe with a select and a data byte.

Top module: `pmon_i2c_target`

## Requirements
- R1: The block acknowledges only address byte {5'b01011, addr_strap, rw} (0x5C/0x5D with strap 2'b10). On any other address it never pulls SDA low until the next START.
- R2: Every byte travels MSB first. The target acknowledges by pulling SDA low through the whole ninth SCL high period, and it changes its SDA drive only while SCL is low.
- R3: A first written byte with bit 7 = 0 loads its bits 6:0 into cmd_q, with cmd_wr high for exactly one cycle. cmd_q is 0 after reset and changes at no other time.
- R4: A first written byte with bit 7 = 1 selects register byte[1:0]. The next byte gives one reg_wr pulse with reg_sel = that select (01, 10 or 11) and reg_data = the byte. Select 00 gives no strobe, and neither case touches cmd_q.
- R5: The voltage channel counts as enabled when cmd_q bit 0 or 1 is set, and the current channel when bit 2 or 3 is set. With both enabled and bit 6 clear, a read returns V[11:4], then I[11:4], then {V[3:0], I[3:0]}.
- R6: With only the current channel enabled, a read returns I[11:4] and then {I[3:0], 4'b0000}. With only voltage, or no channel, it returns the same layout built from V.
- R7: With cmd_q bit 6 set, a read returns status_in as its single byte, and the SDA line stays released for any clocks after it.
- R8: A presence probe (address with write bit, then STOP) is acknowledged and causes no cmd_wr, no reg_wr and no cmd_q change.
- R9: While rd_ready is low, a read address is not acknowledged and SDA stays released. A write address is still acknowledged.
- R10: A master NACK ends data output, so SDA stays released for the rest of the transaction. Every START, repeated or not, restarts the read at the first byte.
- R11: START and STOP are taken only from SDA edges while SCL is high, after two-flop synchronisation. A STOP or START at any point releases SDA and aborts the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_strap | input | 2 | Low two bits of the target address |
| rd_ready | input | 1 | Sequencer has a result that may be read |
| volt_code | input | 12 | Latest voltage conversion code |
| curr_code | input | 12 | Latest current conversion code |
| status_in | input | 8 | Status byte returned on status reads |
| cmd_q | output | 7 | Command bits to the conversion sequencer |
| cmd_wr | output | 1 | One-cycle strobe when cmd_q is written |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_sel | output | 2 | Register select: 01, 10 or 11 |
| reg_data | output | 8 | Register write data |

## Verification
The bench goes after the shared nibble byte and the zero padding of two-byte reads. A design that swaps nibbles or pads the wrong end returns 0x3C instead of 0xC3, or 0x03 instead of 0x30. It sends register select 00 and a presence probe, where a careless decode would emit a stray strobe or clear the command bits. It also declines a read while the sequencer is not ready, and reads past the last byte or past a master NACK, where a design that keeps shifting would pull SDA low. Finally it aborts an address with a STOP and reads again after a repeated START with no STOP, which catches a read pointer that is not reset or a START that is missed.

// File: rtl/pmon_i2c_pkg.sv
package pmon_i2c_pkg;

    localparam int RES_W   = 12;
    localparam int CMD_W   = 7;
    localparam int STRAP_W = 2;
    localparam int PFX_W   = 7 - STRAP_W;
    localparam int NIB_W   = RES_W - 8;
    localparam logic [PFX_W-1:0] ADDR_PFX_DEF = 5'b01011;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD_LOAD,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } bus_state_e;

    typedef enum logic [1:0] {
        FMT_VOLT,
        FMT_CURR,
        FMT_BOTH,
        FMT_STAT
    } rd_fmt_e;

    typedef struct packed {
        rd_fmt_e          fmt;
        logic [RES_W-1:0] v;
        logic [RES_W-1:0] i;
        logic [7:0]       stat;
    } rd_snap_t;

    function automatic rd_fmt_e fmt_of(input logic [CMD_W-1:0] c);
        logic v_on;
        logic i_on;
        v_on = c[0] | c[1];
        i_on = c[2] | c[3];
        if (c[6])
            return FMT_STAT;
        if (v_on && i_on)
            return FMT_BOTH;
        if (i_on)
            return FMT_CURR;
        return FMT_VOLT;
    endfunction

    function automatic logic [1:0] fmt_len(input rd_fmt_e f);
        case (f)
            FMT_STAT: return 2'd1;
            FMT_BOTH: return 2'd3;
            default:  return 2'd2;
        endcase
    endfunction

    function automatic logic [7:0] pack_byte(input rd_snap_t s, input logic [1:0] idx);
        case (s.fmt)
            FMT_STAT: return s.stat;
            FMT_BOTH: begin
                if (idx == 2'd0)
                    return s.v[RES_W-1 -: 8];
                else if (idx == 2'd1)
                    return s.i[RES_W-1 -: 8];
                else
                    return {s.v[NIB_W-1:0], s.i[NIB_W-1:0]};
            end
            FMT_CURR: begin
                if (idx == 2'd0)
                    return s.i[RES_W-1 -: 8];
                else
                    return {s.i[NIB_W-1:0], {(8-NIB_W){1'b0}}};
            end
            default: begin
                if (idx == 2'd0)
                    return s.v[RES_W-1 -: 8];
                else
                    return {s.v[NIB_W-1:0], {(8-NIB_W){1'b0}}};
            end
        endcase
    endfunction

endpackage

// File: rtl/pmon_bus_sync.sv
module pmon_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[SYNC_STAGES-1];
            sda_prev <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_evt = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_evt  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/pmon_rd_packer.sv
module pmon_rd_packer
    import pmon_i2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CMD_W-1:0] cmd,
    input  logic [RES_W-1:0] volt_code,
    input  logic [RES_W-1:0] curr_code,
    input  logic [7:0]       status_in,
    input  logic [1:0]       idx,
    output logic [7:0]       tx_byte,
    output logic [1:0]       rd_len
);

    rd_snap_t snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (load) begin
            snap.fmt  <= fmt_of(cmd);
            snap.v    <= volt_code;
            snap.i    <= curr_code;
            snap.stat <= status_in;
        end
    end

    assign tx_byte = pack_byte(snap, idx);
    assign rd_len  = fmt_len(snap.fmt);

endmodule

// File: rtl/pmon_i2c_fsm.sv
module pmon_i2c_fsm
    import pmon_i2c_pkg::*;
#(
    parameter logic [PFX_W-1:0] ADDR_PFX = ADDR_PFX_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_evt,
    input  logic               stop_evt,
    input  logic               sda_s,
    input  logic [STRAP_W-1:0] strap,
    input  logic               rd_ready,
    input  logic [7:0]         tx_byte,
    input  logic [1:0]         rd_len,
    output logic               snap_load,
    output logic [1:0]         rd_idx,
    output logic               sda_oe,
    output logic [CMD_W-1:0]   cmd_q,
    output logic               cmd_wr,
    output logic               reg_wr,
    output logic [1:0]         reg_sel,
    output logic [7:0]         reg_data
);

    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    bus_state_e st;
    logic [3:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic [1:0] wr_cnt;
    logic       ext_mode;
    logic [1:0] ext_sel;
    logic       is_read;
    logic       m_ack;
    logic [6:0] dev_addr;
    logic       more_bytes;

    assign dev_addr   = {ADDR_PFX, strap};
    assign more_bytes = ({1'b0, rd_idx} + 3'd1) < {1'b0, rd_len};

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            wr_cnt    <= '0;
            ext_mode  <= 1'b0;
            ext_sel   <= '0;
            is_read   <= 1'b0;
            m_ack     <= 1'b0;
            rd_idx    <= '0;
            snap_load <= 1'b0;
            sda_oe    <= 1'b0;
            cmd_q     <= '0;
            cmd_wr    <= 1'b0;
            reg_wr    <= 1'b0;
            reg_sel   <= '0;
            reg_data  <= '0;
        end else begin
            cmd_wr    <= 1'b0;
            reg_wr    <= 1'b0;
            snap_load <= 1'b0;
            if (start_evt) begin
                st       <= ST_ADDR;
                bit_cnt  <= '0;
                rd_idx   <= '0;
                wr_cnt   <= '0;
                ext_mode <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (stop_evt) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == BITS_PER_BYTE) begin
                            if (rx_sh[7:1] == dev_addr && (!rx_sh[0] || rd_ready)) begin
                                st        <= ST_ADDR_ACK;
                                sda_oe    <= 1'b1;
                                is_read   <= rx_sh[0];
                                snap_load <= rx_sh[0];
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            st      <= is_read ? ST_RD_LOAD : ST_WR;
                        end
                    end
                    ST_WR: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == BITS_PER_BYTE) begin
                            st     <= ST_WR_ACK;
                            sda_oe <= 1'b1;
                            if (wr_cnt == 2'd0) begin
                                if (!rx_sh[7]) begin
                                    cmd_q  <= rx_sh[CMD_W-1:0];
                                    cmd_wr <= 1'b1;
                                end else begin
                                    ext_mode <= 1'b1;
                                    ext_sel  <= rx_sh[1:0];
                                end
                            end else if (wr_cnt == 2'd1 && ext_mode && ext_sel != 2'b00) begin
                                reg_wr   <= 1'b1;
                                reg_sel  <= ext_sel;
                                reg_data <= rx_sh;
                            end
                            if (wr_cnt != 2'd3)
                                wr_cnt <= wr_cnt + 2'd1;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            st      <= ST_WR;
                        end
                    end
                    ST_RD_LOAD: begin
                        tx_sh   <= tx_byte;
                        sda_oe  <= ~tx_byte[7];
                        bit_cnt <= '0;
                        st      <= ST_RD;
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == BITS_PER_BYTE) begin
                                st     <= ST_RD_ACK;
                                sda_oe <= 1'b0;
                            end else begin
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                sda_oe <= ~tx_sh[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (m_ack && more_bytes) begin
                                rd_idx <= rd_idx + 2'd1;
                                st     <= ST_RD_LOAD;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pmon_i2c_target.sv
module pmon_i2c_target
    import pmon_i2c_pkg::*;
#(
    parameter logic [PFX_W-1:0] ADDR_PFX    = ADDR_PFX_DEF,
    parameter int               SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] addr_strap,
    input  logic               rd_ready,
    input  logic [RES_W-1:0]   volt_code,
    input  logic [RES_W-1:0]   curr_code,
    input  logic [7:0]         status_in,
    output logic [CMD_W-1:0]   cmd_q,
    output logic               cmd_wr,
    output logic               reg_wr,
    output logic [1:0]         reg_sel,
    output logic [7:0]         reg_data
);

    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_evt;
    logic       stop_evt;
    logic       snap_load;
    logic [1:0] rd_idx;
    logic [7:0] tx_byte;
    logic [1:0] rd_len;

    pmon_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    pmon_rd_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .load      (snap_load),
        .cmd       (cmd_q),
        .volt_code (volt_code),
        .curr_code (curr_code),
        .status_in (status_in),
        .idx       (rd_idx),
        .tx_byte   (tx_byte),
        .rd_len    (rd_len)
    );

    pmon_i2c_fsm #(.ADDR_PFX(ADDR_PFX)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_s     (sda_s),
        .strap     (addr_strap),
        .rd_ready  (rd_ready),
        .tx_byte   (tx_byte),
        .rd_len    (rd_len),
        .snap_load (snap_load),
        .rd_idx    (rd_idx),
        .sda_oe    (sda_oe),
        .cmd_q     (cmd_q),
        .cmd_wr    (cmd_wr),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_data  (reg_data)
    );

endmodule

// File: rtl/pmon_i2c_chk.sv
module pmon_i2c_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_s,
    input logic       stop_evt,
    input logic       sda_oe,
    input logic       cmd_wr,
    input logic [6:0] cmd_q,
    input logic       reg_wr,
    input logic [1:0] reg_sel
);

    p_cmd_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> !cmd_wr);

    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |-> $stable(cmd_q));

    p_sel_valid_r4: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> reg_sel != 2'b00);

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && cmd_wr));

    p_stop_release_r11: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_oe);

    p_drive_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);

endmodule

bind pmon_i2c_target pmon_i2c_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .stop_evt (stop_evt),
    .sda_oe   (sda_oe),
    .cmd_wr   (cmd_wr),
    .cmd_q    (cmd_q),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel)
);

// File: tb/pmon_i2c_target_tb.sv
`timescale 1ns/1ps
module pmon_i2c_target_tb;

    localparam int Q = 8;
    localparam logic [6:0] MY_ADDR = 7'b0101110;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe;
    logic        sda_bus;
    logic [1:0]  addr_strap = 2'b10;
    logic        rd_ready = 1'b1;
    logic [11:0] volt_code = 12'hABC;
    logic [11:0] curr_code = 12'h123;
    logic [7:0]  status_in = 8'h5A;
    logic [6:0]  cmd_q;
    logic        cmd_wr;
    logic        reg_wr;
    logic [1:0]  reg_sel;
    logic [7:0]  reg_data;

    int   nchk = 0;
    int   nbad = 0;
    int   cw_cnt = 0;
    bit   drv_seen = 0;
    bit   model_on = 0;
    bit   done = 0;
    logic [6:0] exp_cmd = '0;
    logic [9:0] wq[$];
    logic [7:0] rb[4];

    always #2.5 clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    pmon_i2c_target u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_oe     (sda_oe),
        .addr_strap (addr_strap),
        .rd_ready   (rd_ready),
        .volt_code  (volt_code),
        .curr_code  (curr_code),
        .status_in  (status_in),
        .cmd_q      (cmd_q),
        .cmd_wr     (cmd_wr),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_data   (reg_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model compared on every clock while the bus is idle
    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_wr) cw_cnt++;
            if (reg_wr) wq.push_back({reg_sel, reg_data});
            if (sda_oe) drv_seen = 1;
            if (model_on) chk(cmd_q === exp_cmd, "R3 cmd model", cmd_q, exp_cmd);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        model_on = 0;
        m_sda = 1; wait_n(Q);
        m_scl = 1; wait_n(Q);
        m_sda = 0; wait_n(Q);
        m_scl = 0; wait_n(Q);
    endtask

    task automatic m_stop();
        m_sda = 0; wait_n(Q);
        m_scl = 1; wait_n(Q);
        m_sda = 1; wait_n(2*Q);
        model_on = 1;
    endtask

    task automatic m_bit(input bit b, output bit r);
        m_sda = b; wait_n(Q);
        m_scl = 1; wait_n(Q);
        r = sda_bus; wait_n(Q);
        m_scl = 0; wait_n(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] b, output bit ack);
        bit r;
        for (int k = 7; k >= 0; k--) m_bit(b[k], r);
        m_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic m_rbyte(input bit give_ack, output logic [7:0] d);
        bit r;
        d = '0;
        for (int k = 0; k < 8; k++) begin
            m_bit(1'b1, r);
            d = {d[6:0], r};
        end
        m_bit(~give_ack, r);
    endtask

    task automatic wr2(input logic [7:0] b0, output bit a0, output bit a1);
        bit aa;
        m_start();
        m_wbyte({MY_ADDR, 1'b0}, aa);
        m_wbyte(b0, a1);
        a0 = aa;
        m_stop();
    endtask

    task automatic rd_n(input int n, input bit ack_last, output bit aack);
        logic [7:0] d;
        m_start();
        m_wbyte({MY_ADDR, 1'b1}, aack);
        for (int k = 0; k < n; k++) begin
            m_rbyte((k != n-1) || ack_last, d);
            rb[k] = d;
        end
        m_stop();
    endtask

    task automatic set_cmd(input logic [6:0] c);
        bit a0, a1;
        wr2({1'b0, c}, a0, a1);
        exp_cmd = c;
        chk(a0 && a1, "R2 command acks", {a0, a1}, 2'b11);
    endtask

    task automatic ext_wr(input logic [7:0] sel_byte, input logic [7:0] val);
        bit a0, a1, a2;
        m_start();
        m_wbyte({MY_ADDR, 1'b0}, a0);
        m_wbyte(sel_byte, a1);
        m_wbyte(val, a2);
        m_stop();
        chk(a0 && a1 && a2, "R4 extended acks", {a0, a1, a2}, 3'b111);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        bit a0, a1, ak;
        int c0;
        logic [9:0] e;
        wait_n(5);
        rst = 0;
        wait_n(2);
        // reset state
        chk(sda_oe == 0, "R2 reset sda_oe", sda_oe, 0);
        chk(cmd_q == 0, "R3 reset cmd_q", cmd_q, 0);
        chk(!cmd_wr && !reg_wr, "R4 reset strobes", {cmd_wr, reg_wr}, 0);
        model_on = 1;

        // R1: wrong address (0x58) is ignored
        drv_seen = 0;
        m_start();
        m_wbyte(8'h58, a0);
        m_wbyte(8'h05, a1);
        m_stop();
        chk(!a0, "R1 mismatch addr nack", a0, 0);
        chk(!drv_seen, "R1 mismatch never drives", drv_seen, 0);
        chk(cmd_q == 0, "R1 mismatch no cmd", cmd_q, 0);

        // R8: presence probe
        c0 = cw_cnt;
        m_start();
        m_wbyte({MY_ADDR, 1'b0}, a0);
        m_stop();
        chk(a0, "R8 probe ack", a0, 1);
        chk(cw_cnt == c0 && wq.size() == 0, "R8 probe no writes", cw_cnt - c0 + wq.size(), 0);

        // R3: command write
        set_cmd(7'h05);
        chk(cw_cnt == c0 + 1, "R3 single cmd_wr pulse", cw_cnt - c0, 1);
        chk(cmd_q == 7'h05, "R3 cmd_q loaded", cmd_q, 7'h05);

        // R5: both channels, three bytes
        rd_n(3, 0, ak);
        chk(ak, "R9 read ack when ready", ak, 1);
        chk(rb[0] == 8'hAB, "R5 byte0 V[11:4]", rb[0], 8'hAB);
        chk(rb[1] == 8'h12, "R5 byte1 I[11:4]", rb[1], 8'h12);
        chk(rb[2] == 8'hC3, "R5 byte2 nibbles", rb[2], 8'hC3);

        // R6: voltage only, current only, none
        set_cmd(7'h02);
        rd_n(2, 0, ak);
        chk(rb[0] == 8'hAB && rb[1] == 8'hC0, "R6 volt only", {rb[0], rb[1]}, 16'hABC0);
        set_cmd(7'h08);
        rd_n(2, 0, ak);
        chk(rb[0] == 8'h12 && rb[1] == 8'h30, "R6 curr only", {rb[0], rb[1]}, 16'h1230);
        set_cmd(7'h00);
        rd_n(2, 0, ak);
        chk(rb[0] == 8'hAB && rb[1] == 8'hC0, "R6 no channel", {rb[0], rb[1]}, 16'hABC0);

        // R7: status byte, then released
        set_cmd(7'h45);
        rd_n(2, 0, ak);
        chk(rb[0] == 8'h5A, "R7 status byte", rb[0], 8'h5A);
        chk(rb[1] == 8'hFF, "R7 released after status", rb[1], 8'hFF);

        // R4: extended register writes
        c0 = cw_cnt;
        wq.delete();
        ext_wr(8'h81, 8'h3C);
        ext_wr(8'h82, 8'h7F);
        ext_wr(8'h83, 8'h01);
        ext_wr(8'h80, 8'h55);
        chk(wq.size() == 3, "R4 write count", wq.size(), 3);
        e = (wq.size() > 0) ? wq[0] : '0;
        chk(e == {2'b01, 8'h3C}, "R4 sel01", e, {2'b01, 8'h3C});
        e = (wq.size() > 1) ? wq[1] : '0;
        chk(e == {2'b10, 8'h7F}, "R4 sel10", e, {2'b10, 8'h7F});
        e = (wq.size() > 2) ? wq[2] : '0;
        chk(e == {2'b11, 8'h01}, "R4 sel11", e, {2'b11, 8'h01});
        chk(cw_cnt == c0 && cmd_q == 7'h45, "R4 cmd untouched", cmd_q, 7'h45);

        // R9: not ready
        set_cmd(7'h05);
        rd_ready = 0;
        drv_seen = 0;
        m_start();
        m_wbyte({MY_ADDR, 1'b1}, ak);
        m_rbyte(0, rb[0]);
        m_stop();
        chk(!ak, "R9 read nack not ready", ak, 0);
        chk(!drv_seen, "R9 no drive not ready", drv_seen, 0);
        m_start();
        m_wbyte({MY_ADDR, 1'b0}, ak);
        m_stop();
        chk(ak, "R9 write ack not ready", ak, 1);
        rd_ready = 1;

        // R10: master nack ends output; start resets pointer
        m_start();
        m_wbyte({MY_ADDR, 1'b1}, ak);
        m_rbyte(0, rb[0]);
        m_rbyte(0, rb[1]);
        chk(rb[0] == 8'hAB, "R10 first byte", rb[0], 8'hAB);
        chk(rb[1] == 8'hFF, "R10 released after nack", rb[1], 8'hFF);
        m_start();
        m_wbyte({MY_ADDR, 1'b1}, ak);
        m_rbyte(0, rb[2]);
        m_stop();
        chk(ak && rb[2] == 8'hAB, "R10 R11 repeated start restarts", rb[2], 8'hAB);

        // R11: STOP in the middle of an address aborts
        m_start();
        for (int k = 0; k < 4; k++) m_bit(MY_ADDR[6-k], a1);
        m_stop();
        chk(sda_oe == 0, "R11 released after stop", sda_oe, 0);
        set_cmd(7'h0A);
        chk(cmd_q == 7'h0A, "R11 next transaction works", cmd_q, 7'h0A);

        done = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule